// File: doc/BRIEF.md
# Teletext Insertion Request Generator

This block runs in the 27 MHz video timing domain. On each video line it decides whether teletext is to be inserted. It uses the current line number, the field flag and a separate line mask for each field. On a chosen line it raises a request strobe toward an external teletext source over a programmable span of horizontal positions. It then samples the serial data the source sends back.

A fractional phase accumulator turns the 27 MHz clock into a per-bit sample strobe at the teletext bit rate. The number of bits kept per line is capped at the window length of the selected teletext standard. Each kept bit leaves the block as a one-cycle valid pulse with its data.

A mode input repurposes the request pin to carry a half-rate copy of the clock instead of the request.

Top module: `ttx_request_gen`

## Requirements
- R1: The number of bits captured per selected line is at most 360 when `std_sel` is 2'b00, 296 when it is 2'b01, and 288 when `std_sel[1]` is 1. Sample strobes beyond that count produce no `bit_vld` pulse.
- R2: A line is selected only when `ins_en` is 1, `line_num` lies in 6 to 37, and bit (`line_num` - 6) of the mask for the current field is 1. The field-0 mask is `mask_f0` and the field-1 mask is `mask_f1`. Lines outside 6 to 37 are never selected.
- R3: With `clk_mode` = 0, `req_pin` is 1 in the cycle after a clock edge at which the line was selected and `req_start` <= `hpos` < `req_stop`, and 0 otherwise.
- R4: With `clk_mode` = 1, `req_pin` carries a divide-by-two of `clk`. It toggles on every clock edge, and its first value after reset release is 1.
- R5: The phase accumulator is 16 bits wide. It is cleared at the edge where a selected line has `hpos` = `req_start`. At each later edge of that line it adds `phase_inc`, and a carry out of bit 15 is a sample strobe.
- R6: On a sample strobe that is within the window, `bit_vld` is 1 for the following cycle, and `bit_out` then holds the `txt_in` value present at the strobe edge.
- R7: When the line is not selected, `bit_vld` is 0 after the next edge. `bit_out` is 0 whenever `bit_vld` is 0.
- R8: While `rst_n` is low, `req_pin`, `bit_out` and `bit_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz video clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Teletext insertion enable |
| clk_mode | input | 1 | 1: request pin carries half-rate clock |
| std_sel | input | 2 | Standard: 00 360 bits, 01 296 bits, 1x 288 bits |
| mask_f0 | input | 32 | Line mask for field 0, bit n = line n+6 |
| mask_f1 | input | 32 | Line mask for field 1, bit n = line n+6 |
| line_num | input | 10 | Current line number |
| field | input | 1 | Current field (0 or 1) |
| hpos | input | 11 | Clocks since line start |
| req_start | input | 11 | First request position; capture start |
| req_stop | input | 11 | First position after the request |
| phase_inc | input | 16 | Fractional bit-rate increment |
| txt_in | input | 1 | Serial data from the teletext source |
| req_pin | output | 1 | Request strobe or half-rate clock |
| bit_out | output | 1 | Captured data bit |
| bit_vld | output | 1 | Captured bit valid pulse |

## Verification
The assertions assume that `std_sel` does not change while a line is being captured. The bound on the bit count only holds against the window that was in force when capture began. They also assume that the timing inputs are stable in every cycle except when `hpos` advances.

The stimulus changes the standard, the masks, the modes and the increment only between lines, while idle cycles on an unselected line are running. It drives `hpos` strictly from 0 up through a full line before moving to the next line. Increments are chosen so that some lines run out of strobes before the cap and others exceed it, so both sides of the bound are exercised.

// File: rtl/ttx_request_gen.sv
module ttx_request_gen #(
  parameter int LINE_W     = 10,
  parameter int HPOS_W     = 11,
  parameter int ACC_W      = 16,
  parameter int MASK_W     = 32,
  parameter int FIRST_LINE = 6,
  parameter int LEN_A      = 360,
  parameter int LEN_B      = 296,
  parameter int LEN_C      = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic              clk_mode,
  input  logic [1:0]        std_sel,
  input  logic [MASK_W-1:0] mask_f0,
  input  logic [MASK_W-1:0] mask_f1,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [HPOS_W-1:0] req_start,
  input  logic [HPOS_W-1:0] req_stop,
  input  logic [ACC_W-1:0]  phase_inc,
  input  logic              txt_in,
  output logic              req_pin,
  output logic              bit_out,
  output logic              bit_vld
);

  localparam int CNT_W = $clog2(LEN_A + 1);
  localparam int IDX_W = $clog2(MASK_W);
  localparam logic [LINE_W-1:0] LO_LINE = LINE_W'(FIRST_LINE);
  localparam logic [LINE_W-1:0] HI_LINE = LINE_W'(FIRST_LINE + MASK_W - 1);

  logic [IDX_W-1:0] idx;
  logic             in_rng, mask_bit, sel, in_win, take;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt, win_len;
  logic             act, req_q, xclk_q;

  assign idx      = IDX_W'(line_num - LO_LINE);
  assign in_rng   = (line_num >= LO_LINE) && (line_num <= HI_LINE);
  assign mask_bit = field ? mask_f1[idx] : mask_f0[idx];
  assign sel      = ins_en && in_rng && mask_bit;
  assign in_win   = (hpos >= req_start) && (hpos < req_stop);
  assign sum      = {1'b0, acc} + {1'b0, phase_inc};
  assign take     = act && sum[ACC_W] && (cnt < win_len);
  assign req_pin  = clk_mode ? xclk_q : req_q;

  always_comb begin
    case (std_sel)
      2'b00:   win_len = CNT_W'(LEN_A);
      2'b01:   win_len = CNT_W'(LEN_B);
      default: win_len = CNT_W'(LEN_C);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xclk_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      xclk_q <= ~xclk_q;
      req_q  <= sel && in_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      acc     <= '0;
      cnt     <= '0;
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      bit_out <= 1'b0;
      if (!sel) begin
        act <= 1'b0;
        acc <= '0;
        cnt <= '0;
      end else if (hpos == req_start) begin
        act <= 1'b1;
        acc <= '0;
        cnt <= '0;
      end else if (act) begin
        acc <= sum[ACC_W-1:0];
        if (take) begin
          cnt     <= cnt + CNT_W'(1);
          bit_vld <= 1'b1;
          bit_out <= txt_in;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= win_len); // R1

  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pin && !clk_mode) |-> ($past(hpos) >= $past(req_start) && $past(hpos) < $past(req_stop))); // R3

  AST_REQ_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mode && !$past(ins_en)) |-> !req_pin); // R2

  AST_XCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_mode && $past(clk_mode)) |-> (req_pin != $past(req_pin))); // R4

  AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(ins_en)); // R7

  AST_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |-> !bit_out); // R7

endmodule

// File: tb/ttx_request_gen_test.sv
module ttx_request_gen_test;
  localparam int H = 1728;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_en = 1'b0, clk_mode = 1'b0, field = 1'b0, txt_in = 1'b0;
  logic [1:0]  std_sel = 2'b00;
  logic [31:0] mask_f0 = '0, mask_f1 = '0;
  logic [9:0]  line_num = '0;
  logic [10:0] hpos = '0, req_start = 11'd100, req_stop = 11'd140;
  logic [15:0] phase_inc = 16'd16839;
  logic        req_pin, bit_out, bit_vld;

  int vectors = 0, errors = 0, cycles = 0;
  int vld_seen = 0, req_seen = 0;
  bit running = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  int m_acc, m_cnt, m_len;
  bit m_act, m_req, m_xclk, m_vld, m_bit, m_sel;
  logic [31:0] m_mask;

  ttx_request_gen uut (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .clk_mode(clk_mode),
    .std_sel(std_sel), .mask_f0(mask_f0), .mask_f1(mask_f1),
    .line_num(line_num), .field(field), .hpos(hpos),
    .req_start(req_start), .req_stop(req_stop), .phase_inc(phase_inc),
    .txt_in(txt_in), .req_pin(req_pin), .bit_out(bit_out), .bit_vld(bit_vld)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_act = 0; m_req = 0; m_xclk = 0; m_vld = 0; m_bit = 0;
    end else begin
      m_xclk = !m_xclk;
      m_mask = field ? mask_f1 : mask_f0;
      m_sel = ins_en && line_num >= 6 && line_num <= 37 && m_mask[int'(line_num) - 6];
      m_len = (std_sel == 2'b00) ? 360 : (std_sel == 2'b01) ? 296 : 288;
      m_req = m_sel && hpos >= req_start && hpos < req_stop;
      m_vld = 0; m_bit = 0;
      if (!m_sel) begin
        m_act = 0; m_cnt = 0; m_acc = 0;
      end else if (hpos == req_start) begin
        m_act = 1; m_cnt = 0; m_acc = 0;
      end else if (m_act) begin
        m_acc = m_acc + int'(phase_inc);
        if (m_acc >= 65536) begin
          m_acc = m_acc - 65536;
          if (m_cnt < m_len) begin
            m_vld = 1; m_bit = txt_in; m_cnt++;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (running) begin
      vectors++;
      if (bit_vld) vld_seen++;
      if (req_pin && !clk_mode) req_seen++;
      if (req_pin !== (clk_mode ? m_xclk : m_req)) begin
        errors++;
        $display("FAIL %s req_pin actual %b expected %b at %0t", clk_mode ? "R4" : "R3",
                 req_pin, clk_mode ? m_xclk : m_req, $time);
      end
      if (bit_vld !== m_vld) begin
        errors++;
        $display("FAIL R5 bit_vld actual %b expected %b at %0t", bit_vld, m_vld, $time);
      end
      if (bit_out !== m_bit) begin
        errors++;
        $display("FAIL R6 bit_out actual %b expected %b at %0t", bit_out, m_bit, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_line(input int ln, input bit fld);
    for (int h = 0; h < H; h++) begin
      @(posedge clk); #1;
      line_num = 10'(ln); field = fld; hpos = 11'(h);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txt_in = lfsr[0];
    end
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      line_num = '0; hpos = '0;
    end
  endtask

  function automatic int exp_bits(input int inc, input int len);
    longint n;
    n = (longint'(H - 1 - 100) * inc) / 65536;
    return (n < len) ? int'(n) : len;
  endfunction

  task automatic line_case(input string tag, input int ln, input bit fld, input int exp_v, input int exp_r);
    vld_seen = 0; req_seen = 0;
    run_line(ln, fld);
    check({tag, " bit count"}, vld_seen, exp_v);
    check({tag, " request cycles"}, req_seen, exp_r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 req_pin in reset", int'(req_pin), 0);
    check("R8 bit_vld in reset", int'(bit_vld), 0);
    check("R8 bit_out in reset", int'(bit_out), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    running = 1'b1;
    ins_en = 1'b1;
    mask_f0 = 32'h8000_0001;
    mask_f1 = 32'h0000_0400;

    std_sel = 2'b00; phase_inc = 16'd16839;
    line_case("R1 R5 360-bit cap", 6, 1'b0, exp_bits(16839, 360), 40);
    line_case("R2 top line 37", 37, 1'b0, exp_bits(16839, 360), 40);
    line_case("R2 field0 mask on field1", 6, 1'b1, 0, 0);
    line_case("R2 field1 line 16", 16, 1'b1, exp_bits(16839, 360), 40);
    line_case("R2 line 5 outside", 5, 1'b0, 0, 0);
    line_case("R2 line 38 outside", 38, 1'b0, 0, 0);

    std_sel = 2'b01; phase_inc = 16'd13902;
    line_case("R1 296-bit cap", 6, 1'b0, exp_bits(13902, 296), 40);
    std_sel = 2'b10; phase_inc = 16'd40000;
    line_case("R1 288-bit cap fast", 6, 1'b0, exp_bits(40000, 288), 40);
    std_sel = 2'b11; phase_inc = 16'd10000;
    line_case("R5 288 std below cap", 6, 1'b0, exp_bits(10000, 288), 40);

    req_stop = 11'd600; std_sel = 2'b00; phase_inc = 16'd16839;
    line_case("R3 long request", 37, 1'b0, exp_bits(16839, 360), 500);
    req_stop = 11'd140;

    ins_en = 1'b0;
    line_case("R7 insertion off", 6, 1'b0, 0, 0);
    ins_en = 1'b1;

    clk_mode = 1'b1;
    line_case("R4 clock mode capture", 6, 1'b0, exp_bits(16839, 360), 0);
    clk_mode = 1'b0;

    mask_f0 = '0;
    line_case("R7 unselected line", 20, 1'b0, 0, 0);

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule